// File: doc/BRIEF.md
# DRAM Refresh Request Generator

The block produces periodic refresh requests for a bus unit that runs DRAM refresh cycles. It also supplies the 20-bit physical address to use for each of those cycles. A programmable down-counter sets the spacing of the requests. A single-entry flag holds at most one outstanding request; a new tick that arrives while a request is still waiting replaces it rather than queueing behind it.

The row part of the address comes from a 9-bit feedback shift counter. It walks through all 512 row values in a scrambled order. It steps only when the bus unit signals that a refresh cycle it accepted has finished, so a dropped request never skips a row.

Software programs the block through a small write port. Through it, software sets the upper address bits, the interval and the run/stop bit. The bus unit talks to the block through a request/acknowledge pair and a cycle-finished strobe.

Top module: `rfsh_gen`

## Requirements
- R1: While running, a request is raised once every interval+1 clock cycles, where interval is the last value written with select 1. Writing the interval also reloads the down-counter with that value.
- R2: When the run bit is clear, the down-counter holds its value and no new request is raised.
- R3: A tick sets `ref_req`, and an acknowledge while `ref_req` is high clears it. An acknowledge while `ref_req` is low has no effect.
- R4: Requests are not queued. Ticks that arrive while a request is pending leave exactly one request outstanding. Once that request is serviced, no second one follows unless a new tick occurs.
- R5: The row value steps exactly once on a `ref_done` that follows an accepted acknowledge. A `ref_done` without a preceding accepted acknowledge leaves the row unchanged.
- R6: The row counter resets to 9'h000. Its next value is {s[7:0], s[8]^s[4]^(s[7:0]==0)}. It visits all 512 values before repeating.
- R7: The address layout is as follows. Bits [19:13] hold the base register, bits [12:10] are 0, bits [9:1] hold the row and bit 0 is 1. The reset value is 20'h00001.
- R8: `ref_addr` stays constant from the raising of a request until the `ref_done` that ends its service. A base write made in that window shows up only after the window closes.
- R9: The write port decodes `wr_sel` as follows: 0 sets the base from `wr_data[6:0]`, 1 sets the interval from `wr_data`, and 2 sets the run bit from `wr_data[0]`. Select 3 has no effect.
- R10: Reset is synchronous and active high. It clears the request, the service state, the row, the base, the interval and the run bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 base, 1 interval, 2 run bit, 3 none |
| wr_data | input | CNT_W | Write data |
| ref_req | output | 1 | Refresh request to the bus unit |
| ref_ack | input | 1 | Bus unit accepts the pending request |
| ref_done | input | 1 | Bus unit finished the accepted refresh cycle |
| ref_addr | output | 20 | Registered refresh physical address |

## Verification
The hardest situation to reach is a request that is overtaken by later ticks while a base write lands in the same window. The bench starves the acknowledge over several interval periods and rewrites the base during that time. It then stops the counter before servicing, so that any second, queued request would show up as a stray `ref_req`. It then checks that the address kept the old base and row throughout, and that the row moves by one step only. Full coverage of the 512-value row sequence is reached by servicing 512 consecutive requests at a short interval and marking each row seen.

// File: rtl/rfsh_pkg.sv
package rfsh_pkg;

    localparam int ROW_W  = 9;
    localparam int BASE_W = 7;
    localparam int ZERO_W = 3;
    localparam int ADDR_W = BASE_W + ZERO_W + ROW_W + 1;
    localparam int TAP_HI = ROW_W - 1;
    localparam int TAP_LO = 4;

    typedef enum logic [1:0] {
        SEL_BASE = 2'd0,
        SEL_IVL  = 2'd1,
        SEL_CTRL = 2'd2,
        SEL_NONE = 2'd3
    } wsel_e;

    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [ZERO_W-1:0] zero;
        logic [ROW_W-1:0]  row;
        logic              one;
    } raddr_t;

    // Maximal-length shift feedback extended with the all-zero state.
    function automatic logic [ROW_W-1:0] row_step(input logic [ROW_W-1:0] s);
        logic fb;
        fb = s[TAP_HI] ^ s[TAP_LO] ^ (s[ROW_W-2:0] == '0);
        return {s[ROW_W-2:0], fb};
    endfunction

    function automatic raddr_t compose(input logic [BASE_W-1:0] b,
                                       input logic [ROW_W-1:0]  r);
        raddr_t a;
        a.base = b;
        a.zero = '0;
        a.row  = r;
        a.one  = 1'b1;
        return a;
    endfunction

endpackage

// File: rtl/rfsh_interval_timer.sv
module rfsh_interval_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [CNT_W-1:0] reload_val,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;

    assign tick = run && (cnt_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (run) begin
            if (cnt_q == '0) cnt_q <= reload_val;
            else             cnt_q <= cnt_q - 1'b1;
        end
    end

    AST_RELOAD_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        (tick && !load) |=> (cnt_q == $past(reload_val))); // R1

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (rst)
        (!run && !load) |=> $stable(cnt_q)); // R2

endmodule

// File: rtl/rfsh_req_flag.sv
module rfsh_req_flag (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic ack,
    input  logic done,
    output logic req,
    output logic busy,
    output logic advance
);

    logic req_q;
    logic busy_q;
    logic accept;

    assign accept  = ack && req_q;
    assign advance = busy_q && done;
    assign req     = req_q;
    assign busy    = busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= 1'b0;
            busy_q <= 1'b0;
        end else begin
            req_q  <= tick || (req_q && !ack);
            busy_q <= accept || (busy_q && !done);
        end
    end

    AST_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (rst)
        (req_q && ack && !tick) |=> !req_q); // R3

    AST_TICK_SETS: assert property (@(posedge clk) disable iff (rst)
        tick |=> req_q); // R4

    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (rst)
        (!req_q && !busy_q && !tick) |=> (!req_q && !busy_q)); // R3

endmodule

// File: rtl/rfsh_row_counter.sv
module rfsh_row_counter
    import rfsh_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [ROW_W-1:0] row
);

    logic [ROW_W-1:0] row_q;

    assign row = row_q;

    always_ff @(posedge clk) begin
        if (rst)       row_q <= '0;
        else if (step) row_q <= row_step(row_q);
    end

    AST_ROW_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(row_q)); // R5

endmodule

// File: rtl/rfsh_gen.sv
module rfsh_gen
    import rfsh_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [1:0]        wr_sel,
    input  logic [CNT_W-1:0]  wr_data,
    output logic              ref_req,
    input  logic              ref_ack,
    input  logic              ref_done,
    output logic [ADDR_W-1:0] ref_addr
);

    logic [BASE_W-1:0] base_q;
    logic [CNT_W-1:0]  ivl_q;
    logic              en_q;
    logic              ivl_wr;
    logic              tick;
    logic              req;
    logic              busy;
    logic              advance;
    logic [ROW_W-1:0]  row;
    raddr_t            addr_q;
    raddr_t            addr_d;
    logic              addr_ld;
    wsel_e             sel;

    assign sel    = wsel_e'(wr_sel);
    assign ivl_wr = wr_en && (sel == SEL_IVL);

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            ivl_q  <= '0;
            en_q   <= 1'b0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_BASE: base_q <= wr_data[BASE_W-1:0];
                SEL_IVL:  ivl_q  <= wr_data;
                SEL_CTRL: en_q   <= wr_data[0];
                SEL_NONE: ;
            endcase
        end
    end

    rfsh_interval_timer #(.CNT_W(CNT_W)) i_timer (
        .clk        (clk),
        .rst        (rst),
        .run        (en_q),
        .load       (ivl_wr),
        .load_val   (wr_data),
        .reload_val (ivl_q),
        .tick       (tick)
    );

    rfsh_req_flag i_flag (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .ack     (ref_ack),
        .done    (ref_done),
        .req     (req),
        .busy    (busy),
        .advance (advance)
    );

    rfsh_row_counter i_row (
        .clk  (clk),
        .rst  (rst),
        .step (advance),
        .row  (row)
    );

    // Address follows the state while idle, and takes the stepped row at
    // the edge that closes a service window.
    assign addr_ld = advance || (!req && !busy);
    assign addr_d  = advance ? compose(base_q, row_step(row)) : compose(base_q, row);

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= compose('0, '0);
        else if (addr_ld) addr_q <= addr_d;
    end

    assign ref_req  = req;
    assign ref_addr = addr_q;

    always_comb begin
        AST_FIXED_FIELDS: assert (rst || (addr_q.zero == '0 && addr_q.one == 1'b1)); // R7
    end

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        ((req || busy) && !(busy && ref_done)) |=> $stable(ref_addr)); // R8

    AST_ONE_STEP: assert property (@(posedge clk) disable iff (rst)
        (busy && ref_done) |=> (ref_addr[ROW_W:1] != $past(ref_addr[ROW_W:1]))); // R5

    AST_NO_REQ_STOPPED: assert property (@(posedge clk) disable iff (rst)
        !en_q |=> !$rose(ref_req)); // R2

endmodule

// File: tb/test_rfsh_gen.sv
module test_rfsh_gen;

    localparam int CW = 16;
    localparam int NTAB = 4;
    localparam logic [CW-1:0] IVL_TAB [NTAB] = '{16'd5, 16'd9, 16'd20, 16'd13};
    localparam int            PER_TAB [NTAB] = '{6, 10, 21, 14};

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = 2'd0;
    logic [CW-1:0] wr_data = '0;
    logic          ref_req;
    logic          ref_ack = 1'b0;
    logic          ref_done = 1'b0;
    logic [19:0]   ref_addr;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic [8:0] m_row = '0;
    logic [6:0] m_base = '0;
    logic       finished = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rfsh_gen #(.CNT_W(CW)) i_rfsh_gen (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .ref_req(ref_req), .ref_ack(ref_ack), .ref_done(ref_done), .ref_addr(ref_addr)
    );

    function automatic logic [8:0] m_step(input logic [8:0] s);
        return {s[7:0], s[8] ^ s[4] ^ (s[7:0] == 8'd0)};
    endfunction

    function automatic logic [19:0] m_addr(input logic [6:0] b, input logic [8:0] r);
        return {b, 3'b000, r, 1'b1};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] s, input logic [CW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_req(output int t);
        int n = 0;
        while (!ref_req && n < 2000) begin
            @(negedge clk);
            n++;
        end
        t = cyc;
        chk(ref_req == 1'b1, "R1 request arrives", 32'(ref_req), 32'd1);
    endtask

    // Service the pending request, checking the address and advancing the model.
    task automatic service(input string tag);
        chk(ref_addr == m_addr(m_base, m_row), tag, 32'(ref_addr), 32'(m_addr(m_base, m_row)));
        ref_ack = 1'b1;
        @(negedge clk);
        ref_ack = 1'b0; ref_done = 1'b1;
        @(negedge clk);
        ref_done = 1'b0;
        m_row = m_step(m_row);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        ref_ack = 1'b0; ref_done = 1'b0; wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_row = '0; m_base = '0;
    endtask

    initial begin
        int t0;
        int t1;
        logic [19:0] a_hold;
        bit seen [512];
        bit dup;

        do_reset();
        chk(ref_addr == 20'h00001, "R7 R10 reset address", 32'(ref_addr), 32'h1);
        chk(ref_req == 1'b0, "R10 reset request", 32'(ref_req), 32'd0);

        // R2: stopped counter never raises a request
        wr(2'd1, 16'd3);
        repeat (30) @(negedge clk);
        chk(ref_req == 1'b0, "R2 stopped no request", 32'(ref_req), 32'd0);

        // R9 base write and R7 layout
        wr(2'd0, 16'hFF2A);
        m_base = 7'h2A;
        @(negedge clk);
        chk(ref_addr == m_addr(m_base, m_row), "R9 R7 base field", 32'(ref_addr), 32'(m_addr(m_base, m_row)));
        wr(2'd3, 16'h0055);
        @(negedge clk);
        chk(ref_addr == m_addr(m_base, m_row), "R9 select 3 ignored", 32'(ref_addr), 32'(m_addr(m_base, m_row)));
        repeat (10) @(negedge clk);
        chk(ref_req == 1'b0, "R9 select 3 did not enable", 32'(ref_req), 32'd0);

        // R3/R5: ack without request and done without ack are ignored
        ref_ack = 1'b1; @(negedge clk); ref_ack = 1'b0;
        ref_done = 1'b1; @(negedge clk); ref_done = 1'b0;
        @(negedge clk);
        chk(ref_addr == m_addr(m_base, m_row), "R3 R5 stray ack/done no step", 32'(ref_addr), 32'(m_addr(m_base, m_row)));
        chk(ref_req == 1'b0, "R3 stray ack no request", 32'(ref_req), 32'd0);

        // Table walk: R1 interval periods
        for (int k = 0; k < NTAB; k++) begin
            wr(2'd2, 16'd0);
            if (ref_req) service("R1 drain");
            wr(2'd1, IVL_TAB[k]);
            wr(2'd2, 16'd1);
            wait_req(t0);
            service("R1 address in table walk");
            wait_req(t1);
            chk((t1 - t0) == PER_TAB[k], "R1 period", 32'(t1 - t0), 32'(PER_TAB[k]));
            service("R6 address after step");
        end

        // R4/R8: starve the acknowledge, rewrite base while pending
        wr(2'd2, 16'd0);
        if (ref_req) service("R4 drain");
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd1);
        wait_req(t0);
        a_hold = ref_addr;
        wr(2'd0, 16'h0011);
        repeat (25) @(negedge clk);
        chk(ref_req == 1'b1, "R4 single request still pending", 32'(ref_req), 32'd1);
        chk(ref_addr == a_hold, "R8 address held while pending", 32'(ref_addr), 32'(a_hold));
        wr(2'd2, 16'd0);
        service("R4 R8 address keeps old base");
        m_base = 7'h11;
        @(negedge clk);
        chk(ref_addr == m_addr(m_base, m_row), "R5 R8 one step and new base", 32'(ref_addr), 32'(m_addr(m_base, m_row)));
        repeat (20) @(negedge clk);
        chk(ref_req == 1'b0, "R4 no queued second request", 32'(ref_req), 32'd0);

        // R6: full sequence coverage from reset
        do_reset();
        foreach (seen[i]) seen[i] = 1'b0;
        dup = 1'b0;
        wr(2'd1, 16'd5);
        wr(2'd2, 16'd1);
        for (int n = 0; n < 512; n++) begin
            wait_req(t0);
            if (seen[ref_addr[9:1]]) dup = 1'b1;
            seen[ref_addr[9:1]] = 1'b1;
            service("R6 sequence address");
        end
        chk(dup == 1'b0, "R6 no repeat in 512 steps", 32'(dup), 32'd0);
        chk(m_row == 9'h000, "R6 wraps to start", 32'(m_row), 32'd0);

        // R10: reset in the middle of activity
        wait_req(t0);
        do_reset();
        chk(ref_req == 1'b0, "R10 mid-run reset request", 32'(ref_req), 32'd0);
        chk(ref_addr == 20'h00001, "R10 mid-run reset address", 32'(ref_addr), 32'h1);
        repeat (30) @(negedge clk);
        chk(ref_req == 1'b0, "R10 run bit cleared", 32'(ref_req), 32'd0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule